// File: doc/BRIEF.md
# Six-State Saturating Up-Counter with Fault Flag

This block is a 3-bit up-counter with six legal values, 0 through 5. From zero it rises by one on each rising clock edge. When it reaches 5 it stays there until it is cleared. It is meant for short fixed-length delays and "has enough time passed" qualifiers, where the count has to pin at its top value rather than wrap.

Two active-high synchronous inputs return it to zero. The first, an initialization reset, is held for the first cycles after power-up and wins over everything else. The second, a counter clear, is used during normal operation: it restarts the count from any value, and it holds the count at zero for as long as it stays high.

The encodings 6 and 7 are not legal states, and a fault flag reports them. Once the state register holds either value, the count stays there until one of the two resets arrives, so the fault remains visible. Both outputs come directly from flip-flops. The named states are ST_ZERO, ST_ONE, ST_TWO, ST_THREE, ST_FOUR, ST_TOP (the legal ones) and ST_BAD6, ST_BAD7 (the illegal ones). The transitions are:

- step: each ST_ZERO to ST_FOUR state moves to the next state.
- park: ST_TOP moves to itself.
- trap: each bad state moves to itself.
- restart: any state moves to ST_ZERO under either reset.

Top module: `satcnt`

## Requirements
- R1: While `init_rst_i` is high at a rising edge, the next `count_o` is 0 and the next `err_o` is 0, whatever `clear_i` is.
- R2: With both resets low and `count_o` below 5, each rising edge raises `count_o` by exactly one.
- R3: With both resets low and `count_o` equal to 5, `count_o` stays 5 on every later edge.
- R4: With `init_rst_i` low and `clear_i` high at a rising edge, `count_o` becomes 0, even from a mid-count or saturated value.
- R5: While `clear_i` stays high over several edges, `count_o` stays 0.
- R6: `err_o` is 1 exactly when the state encoding is 6 or 7, and 0 for every legal value 0 to 5. An illegal encoding holds until a reset or clear occurs.
- R7: On the first edge after `clear_i` or `init_rst_i` falls, `count_o` goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every state change happens on its rising edge |
| init_rst_i | input | 1 | Active-high synchronous initialization reset, highest priority |
| clear_i | input | 1 | Active-high synchronous counter clear |
| count_o | output | 3 | Registered count, 0 to 5 in legal operation |
| err_o | output | 1 | Registered flag, high while the state is an illegal encoding |

## Verification
The bench targets the following corner cases:

- Clear while saturated: a design with a wrong priority would keep 5.
- Clear held for several cycles: a design that lets the count creep up to 1 while clear is high would fail here.
- Both resets asserted together.
- Release from zero: an off-by-one design would show 2, or would miss a cycle.
- Long runs with no clear: a wrapping design would return to 0 or step into 6, which would also raise the fault flag.

A pseudo-random mix of clear and reset pulses is compared against a behavioural model on every cycle.

// File: rtl/satcnt_pkg.sv
package satcnt_pkg;
    localparam int CNT_W   = 3;
    localparam int TOP_VAL = 5;

    typedef enum logic [CNT_W-1:0] {
        ST_ZERO  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_THREE = 3'd3,
        ST_FOUR  = 3'd4,
        ST_TOP   = 3'd5,
        ST_BAD6  = 3'd6,
        ST_BAD7  = 3'd7
    } cnt_state_e;
endpackage

// File: rtl/satcnt_next.sv
module satcnt_next
    import satcnt_pkg::*;
(
    input  cnt_state_e cur_i,
    input  logic       init_rst_i,
    input  logic       clear_i,
    output cnt_state_e nxt_o,
    output logic       nxt_bad_o
);
    cnt_state_e step_nxt;

    always_comb begin
        unique case (cur_i)
            ST_ZERO:  step_nxt = ST_ONE;
            ST_ONE:   step_nxt = ST_TWO;
            ST_TWO:   step_nxt = ST_THREE;
            ST_THREE: step_nxt = ST_FOUR;
            ST_FOUR:  step_nxt = ST_TOP;
            ST_TOP:   step_nxt = ST_TOP;   // park
            ST_BAD6:  step_nxt = ST_BAD6;  // trap
            ST_BAD7:  step_nxt = ST_BAD7;  // trap
        endcase
    end

    always_comb begin
        if (init_rst_i || clear_i) nxt_o = ST_ZERO;   // restart
        else                       nxt_o = step_nxt;
    end

    assign nxt_bad_o = (nxt_o == ST_BAD6) || (nxt_o == ST_BAD7);
endmodule

// File: rtl/satcnt_regs.sv
module satcnt_regs
    import satcnt_pkg::*;
(
    input  logic       clk_i,
    input  logic       init_rst_i,
    input  cnt_state_e nxt_i,
    input  logic       nxt_bad_i,
    output cnt_state_e state_o,
    output logic       err_o
);
    // state register
    always_ff @(posedge clk_i) begin
        if (init_rst_i) state_o <= ST_ZERO;
        else            state_o <= nxt_i;
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (init_rst_i) err_o <= 1'b0;
        else            err_o <= nxt_bad_i;
    end
endmodule

// File: rtl/satcnt.sv
module satcnt
    import satcnt_pkg::*;
(
    input  logic             clk_i,
    input  logic             init_rst_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o,
    output logic             err_o
);
    cnt_state_e nxt_s;
    cnt_state_e state_s;
    logic       nxt_bad_s;

    satcnt_next u_next (
        .cur_i      (state_s),
        .init_rst_i (init_rst_i),
        .clear_i    (clear_i),
        .nxt_o      (nxt_s),
        .nxt_bad_o  (nxt_bad_s)
    );

    satcnt_regs u_regs (
        .clk_i      (clk_i),
        .init_rst_i (init_rst_i),
        .nxt_i      (nxt_s),
        .nxt_bad_i  (nxt_bad_s),
        .state_o    (state_s),
        .err_o      (err_o)
    );

    assign count_o = state_s;

    // R1
    init_zero_chk: assert property (@(posedge clk_i) disable iff (init_rst_i)
        $fell(init_rst_i) |-> (count_o == '0) && !err_o);
    // R2
    step_up_chk: assert property (@(posedge clk_i) disable iff (init_rst_i)
        (!clear_i && count_o < CNT_W'(TOP_VAL)) |=> (count_o == $past(count_o) + 1'b1));
    // R3
    park_top_chk: assert property (@(posedge clk_i) disable iff (init_rst_i)
        (!clear_i && count_o == CNT_W'(TOP_VAL)) |=> (count_o == CNT_W'(TOP_VAL)));
    // R4
    clear_zero_chk: assert property (@(posedge clk_i) disable iff (init_rst_i)
        clear_i |=> (count_o == '0));
    // R6
    err_match_chk: assert property (@(posedge clk_i) disable iff (init_rst_i)
        err_o == (count_o > CNT_W'(TOP_VAL)));
    // R6
    bad_trap_chk: assert property (@(posedge clk_i) disable iff (init_rst_i)
        (!clear_i && count_o > CNT_W'(TOP_VAL)) |=> $stable(count_o));
endmodule

// File: tb/satcnt_test.sv
module satcnt_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       init_rst = 1'b1;
    logic       clear = 1'b0;
    logic [2:0] count;
    logic       err;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit done   = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    satcnt uut (
        .clk_i      (clk),
        .init_rst_i (init_rst),
        .clear_i    (clear),
        .count_o    (count),
        .err_o      (err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive at negedge, model updates at posedge, compare at next negedge.
    task automatic step(input logic r, input logic c);
        string tag;
        int prev;
        prev = model;
        init_rst = r;
        clear = c;
        @(posedge clk);
        if (r)               model = 0;
        else if (c)          model = 0;
        else if (model < 5)  model = model + 1;
        if (r)               tag = "R1";
        else if (c)          tag = (prev == 0) ? "R5" : "R4";
        else if (prev == 0)  tag = "R7";
        else if (prev < 5)   tag = "R2";
        else                 tag = "R3";
        @(negedge clk);
        check(tag, int'(count), model);
        check("R6", int'(err), 0);
    endtask

    initial begin
        @(negedge clk);
        step(1, 0);            // R1 reset state
        step(1, 1);            // R1 priority over clear
        repeat (9) step(0, 0); // R2, R7, R3 saturate and park
        step(0, 1);            // R4 clear from saturated
        repeat (3) step(0, 0);
        step(0, 1);            // R4 clear mid-count
        repeat (4) step(0, 1); // R5 clear held
        step(0, 0);            // R7 release
        step(0, 0);
        step(1, 0);            // R1 reset mid-count
        step(1, 0);
        repeat (7) step(0, 0);
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:0] == 8'h00, lfsr[2:0] == 3'b000);
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule